// File: doc/BRIEF.md
# Sprite Attribute Table Write Port

This block is the processor-side write path into a sprite attribute store of 544 bytes. The store holds 128 sprites. A main table gives each sprite four bytes: horizontal position low byte, vertical position, and a 16-bit attribute word. A high table gives each sprite two more bits: horizontal position bit 8 and a size select. Software loads a 9-bit word address and then streams bytes through a single data input. An internal phase bit says whether the next byte is the first or the second half of a word.

Main-table words are committed only when both halves have arrived. The first byte waits in a holding latch, and the second byte writes the whole word at once, so a half-written word is never visible. High-table bytes go straight into storage as each one arrives. An optional rotation mode tracks the write address and produces a "first sprite" index, which a renderer can use as its starting sprite. A lookup port decodes the fields of any one sprite from the stored bytes.

Top module: `sprite_attr_wport`

## Requirements
- R1: After reset the word address, the phase bit and the first-sprite index are zero, and every decoded field of every sprite is zero.
- R2: A pulse on `addr_load` loads `addr_in` into the word address, clears the phase bit and discards any pending first byte. When `addr_load` and `wr_en` are high in the same cycle, the write is ignored.
- R3: Every accepted write (`wr_en` high with `addr_load` low) inverts the phase bit.
- R4: When address bit 8 is 0 and the phase is 0, a write only holds the byte in the latch: no sprite field and no address change. When the phase is 1, the word at address[7:0] becomes {new byte, latched byte}, with the latched byte in the low half. The address then increments.
- R5: Sprite n owns word 2n and word 2n+1. For word 2n, bits 7:0 are X[7:0] and bits 15:8 are Y. For word 2n+1, bits 8:0 are the tile name, 11:9 the palette, 13:12 the priority, 14 the horizontal flip and 15 the vertical flip.
- R6: When address bit 8 is 1, each byte is stored at once at high-table byte index {address[3:0], phase}. Address bits 7:4 are ignored. The address increments only after the phase-1 byte.
- R7: High-table byte b covers sprites 4b to 4b+3. Sprite 4b+j takes X bit 8 from bit 2j and its size select from bit 2j+1.
- R8: The word address is 9 bits wide. It steps from 0x0FF into the high table at 0x100, and wraps from 0x1FF to 0x000.
- R9: When `rot_en` is high, each address increment sets the first-sprite index to bits 7:1 of the new address. At any other time the index holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_load | input | 1 | Load word address from `addr_in` |
| addr_in | input | 9 | Word address value to load |
| wr_en | input | 1 | Data byte strobe |
| wr_data | input | 8 | Data byte |
| rot_en | input | 1 | Enable first-sprite rotation tracking |
| spr_sel | input | 7 | Sprite selected for the decode port |
| word_addr | output | 9 | Current word address |
| phase | output | 1 | Phase bit (1 = a first byte is pending) |
| first_spr | output | 7 | First-sprite index |
| spr_x | output | 9 | Selected sprite X position |
| spr_y | output | 8 | Selected sprite Y position |
| spr_name | output | 9 | Selected sprite tile name |
| spr_pal | output | 3 | Selected sprite palette |
| spr_prio | output | 2 | Selected sprite priority |
| spr_hflip | output | 1 | Selected sprite horizontal flip |
| spr_vflip | output | 1 | Selected sprite vertical flip |
| spr_big | output | 1 | Selected sprite size select |

## Verification
The assertions check the address and phase sequencing on every cycle. They cover load precedence, the phase toggle, the hold of the address on the first main-table byte, single-step increments with the 9-bit wrap, and the first-sprite index following or holding. Where bytes land in storage, and how the decode port splits them into fields, can only be shown by the bench's scenarios. Those scenarios fill the whole store through both tables and read back all 128 sprites. They also cover an abandoned first byte, a load that coincides with a write, aliasing of the high-table address, and rotation across both table boundaries.

// File: rtl/sprite_attr_wport.sv
module sprite_attr_wport #(
  parameter int NUM_SPRITES = 128,
  localparam int SW  = $clog2(NUM_SPRITES),
  localparam int AW  = SW + 2,
  localparam int MW  = NUM_SPRITES * 2,
  localparam int HB  = NUM_SPRITES / 4,
  localparam int HBW = $clog2(HB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr_load,
  input  logic [AW-1:0] addr_in,
  input  logic          wr_en,
  input  logic [7:0]    wr_data,
  input  logic          rot_en,
  input  logic [SW-1:0] spr_sel,
  output logic [AW-1:0] word_addr,
  output logic          phase,
  output logic [SW-1:0] first_spr,
  output logic [8:0]    spr_x,
  output logic [7:0]    spr_y,
  output logic [8:0]    spr_name,
  output logic [2:0]    spr_pal,
  output logic [1:0]    spr_prio,
  output logic          spr_hflip,
  output logic          spr_vflip,
  output logic          spr_big
);

  logic [AW-1:0] addr_q;
  logic          flip_q;
  logic [7:0]    latch_q;
  logic [SW-1:0] first_q;
  logic [15:0]   main_q [MW];
  logic [7:0]    hi_q   [HB];

  wire           acc     = wr_en & ~addr_load;
  wire           in_hi   = addr_q[AW-1];
  wire           advance = acc & flip_q;
  wire [AW-1:0]  addr_nx = addr_q + 1'b1;
  wire [HBW-1:0] hi_idx  = {addr_q[HBW-2:0], flip_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      flip_q  <= 1'b0;
      latch_q <= '0;
      first_q <= '0;
      for (int i = 0; i < MW; i++) main_q[i] <= '0;
      for (int i = 0; i < HB; i++) hi_q[i] <= '0;
    end else if (addr_load) begin
      addr_q <= addr_in;
      flip_q <= 1'b0;
    end else if (wr_en) begin
      flip_q <= ~flip_q;
      if (advance) addr_q <= addr_nx;
      if (advance && rot_en) first_q <= addr_nx[AW-2:1];
      if (in_hi) hi_q[hi_idx] <= wr_data;
      else if (!flip_q) latch_q <= wr_data;
      else main_q[addr_q[AW-2:0]] <= {wr_data, latch_q};
    end
  end

  wire [15:0] pos_w  = main_q[{spr_sel, 1'b0}];
  wire [15:0] attr_w = main_q[{spr_sel, 1'b1}];
  wire [7:0]  hi_b   = hi_q[spr_sel[SW-1:2]];
  wire [1:0]  hi_p   = 2'(hi_b >> {spr_sel[1:0], 1'b0});

  assign word_addr = addr_q;
  assign phase     = flip_q;
  assign first_spr = first_q;
  assign spr_x     = {hi_p[0], pos_w[7:0]};
  assign spr_y     = pos_w[15:8];
  assign spr_name  = attr_w[8:0];
  assign spr_pal   = attr_w[11:9];
  assign spr_prio  = attr_w[13:12];
  assign spr_hflip = attr_w[14];
  assign spr_vflip = attr_w[15];
  assign spr_big   = hi_p[1];

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    addr_load |=> (addr_q == $past(addr_in)) && !flip_q);

  p_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr_load) |=> flip_q != $past(flip_q));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr_load && !flip_q) |=> $stable(addr_q));

  p_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr_load && flip_q) |=> addr_q == AW'($past(addr_q) + 1'b1));

  p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr_load && flip_q && (&addr_q)) |=> addr_q == '0);

  p_rot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr_load && flip_q && rot_en) |=> first_q == addr_q[AW-2:1]);

  p_norot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && !addr_load && flip_q && rot_en) |=> $stable(first_q));

endmodule

// File: tb/tb_sprite_attr_wport.sv
`timescale 1ns/1ps
module tb_sprite_attr_wport;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       addr_load = 1'b0;
  logic [8:0] addr_in = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rot_en = 1'b0;
  logic [6:0] spr_sel = '0;
  logic [8:0] word_addr;
  logic       phase;
  logic [6:0] first_spr;
  logic [8:0] spr_x;
  logic [7:0] spr_y;
  logic [8:0] spr_name;
  logic [2:0] spr_pal;
  logic [1:0] spr_prio;
  logic       spr_hflip, spr_vflip, spr_big;

  sprite_attr_wport dut (
    .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
    .wr_en(wr_en), .wr_data(wr_data), .rot_en(rot_en), .spr_sel(spr_sel),
    .word_addr(word_addr), .phase(phase), .first_spr(first_spr),
    .spr_x(spr_x), .spr_y(spr_y), .spr_name(spr_name), .spr_pal(spr_pal),
    .spr_prio(spr_prio), .spr_hflip(spr_hflip), .spr_vflip(spr_vflip),
    .spr_big(spr_big)
  );

  always #2.5 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;

  int         m_addr = 0;
  int         m_flip = 0;
  int         m_first = 0;
  logic [7:0] m_latch = '0;
  logic [15:0] m_main [256];
  logic [7:0]  m_hi [32];

  task automatic chk(string tag, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
  end

  task automatic ld(input int a);
    @(negedge clk);
    addr_load = 1'b1;
    addr_in = 9'(a);
    @(negedge clk);
    addr_load = 1'b0;
    m_addr = a & 511;
    m_flip = 0;
  endtask

  task automatic wr(input logic [7:0] d);
    bit adv;
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    adv = (m_flip == 1);
    if (m_addr >= 256) m_hi[((m_addr & 15) << 1) | m_flip] = d;
    else if (m_flip == 0) m_latch = d;
    else m_main[m_addr & 255] = {d, m_latch};
    m_flip ^= 1;
    if (adv) begin
      m_addr = (m_addr + 1) & 511;
      if (rot_en) m_first = (m_addr & 8'hFE) >> 1;
    end
  endtask

  task automatic ld_and_wr(input int a, input logic [7:0] d);
    @(negedge clk);
    addr_load = 1'b1;
    addr_in = 9'(a);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    addr_load = 1'b0;
    wr_en = 1'b0;
    m_addr = a & 511;
    m_flip = 0;
  endtask

  function automatic longint exp_spr(int n);
    logic [15:0] p, a;
    logic [1:0]  h;
    p = m_main[2*n];
    a = m_main[2*n+1];
    h = 2'((m_hi[n/4] >> (2*(n%4))) & 8'h3);
    return longint'({h[0], p[7:0], p[15:8], a[8:0], a[11:9], a[13:12],
                     a[14], a[15], h[1]});
  endfunction

  task automatic check_state(string tag);
    chk({tag, " addr"}, longint'(word_addr), longint'(m_addr));
    chk({tag, " phase"}, longint'(phase), longint'(m_flip));
    chk({tag, " first"}, longint'(first_spr), longint'(m_first));
  endtask

  task automatic check_all(string tag);
    for (int n = 0; n < 128; n++) begin
      spr_sel = 7'(n);
      #1;
      chk(tag, longint'({spr_x, spr_y, spr_name, spr_pal, spr_prio,
                         spr_hflip, spr_vflip, spr_big}), exp_spr(n));
    end
    check_state(tag);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) m_main[i] = '0;
    for (int i = 0; i < 32; i++) m_hi[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    check_all("R1 reset");

    // R4/R5: fill the whole main table in one stream
    ld(0);
    for (int w = 0; w < 256; w++) begin
      wr(8'((w * 37 + 11) & 255));
      chk("R3 phase after first byte", longint'(phase), 1);
      wr(8'((w * 91 + 200) & 255));
    end
    chk("R8 main-to-high step", longint'(word_addr), 256);
    check_all("R5 main decode");

    // R6/R7: fill the whole high table
    for (int b = 0; b < 32; b++) wr(8'((b * 53 + 90) & 255));
    chk("R6 high fill addr", longint'(word_addr), 272);
    check_all("R7 high decode");

    // R4: first byte held only
    ld(10);
    wr(8'h11);
    check_all("R4 first byte invisible");
    wr(8'h22);
    spr_sel = 7'd5;
    #1;
    chk("R4 pair X low", longint'(spr_x[7:0]), 8'h11);
    chk("R4 pair Y", longint'(spr_y), 8'h22);
    check_all("R4 pair commit");

    // R2: reload drops pending byte, load wins over write
    ld(11);
    wr(8'h33);
    ld(11);
    wr(8'h44);
    wr(8'h55);
    spr_sel = 7'd5;
    #1;
    chk("R2 dropped byte name", longint'(spr_name), 9'h144);
    chk("R2 dropped byte pal", longint'(spr_pal), 2);
    check_all("R2 reload");
    wr(8'h77);
    ld_and_wr(40, 8'hEE);
    check_all("R2 load priority");
    wr(8'h01);
    ld_and_wr(300, 8'hEE);
    check_all("R2 load priority high");

    // R6: aliasing and immediate commit
    ld(9'h1F3);
    wr(8'hA5);
    check_all("R6 immediate high byte");
    wr(8'h5A);
    chk("R6 alias addr", longint'(word_addr), 9'h1F4);
    check_all("R6 alias");

    // R8: wrap
    ld(9'h1FF);
    wr(8'hC3);
    wr(8'h3C);
    chk("R8 wrap", longint'(word_addr), 0);
    check_all("R8 wrap");

    // R9: rotation
    rot_en = 1'b1;
    ld(10);
    wr(8'h01);
    chk("R9 no advance hold", longint'(first_spr), 0);
    wr(8'h02);
    chk("R9 first follows", longint'(first_spr), 5);
    ld(9'h13);
    wr(8'h03);
    wr(8'h04);
    chk("R9 odd addr", longint'(first_spr), 10);
    rot_en = 1'b0;
    ld(9'h40);
    wr(8'h05);
    wr(8'h06);
    chk("R9 disabled hold", longint'(first_spr), 10);
    rot_en = 1'b1;
    ld(9'h121);
    wr(8'h07);
    wr(8'h08);
    chk("R9 high table", longint'(first_spr), 9'h11);
    ld(9'h1FF);
    wr(8'h09);
    wr(8'h0A);
    chk("R9 wrap", longint'(first_spr), 0);
    check_all("R9 final");

    finish_run();
  end
endmodule